// File: doc/BRIEF.md
# Configurable Stub Inference Stream Engine

This block stands in for a neural-network compute engine in system bring-up. It does no arithmetic at all. A host programs up to four model slots over an AXI4-Lite slave. Each slot holds four words: an input size, an output size, a delay and an enable. The data path then runs one transaction at a time. A model number arrives on a dedicated AXI4-Stream select port. The engine takes the number of input beats that the chosen slot implies. It then idles for the configured number of cycles and sends an output packet of the configured length.

Every output beat carries a small synthetic tag in place of a result: its own index within the packet and the model number. Downstream logic can therefore check ordering, packet length, byte-valid masks and latency without any real model. The input stream has no framing of its own, so the select word together with the slot registers defines each packet's shape.

A select word that names a disabled slot or a slot that does not exist is flagged in a sticky status bit. No output is produced for it.

Top module: `stub_infer_engine`

## Requirements
- R1: Slot n (0..3) is mapped at byte address 0x10_0000 + 16·n. Its words sit at +0x0 (input size), +0x4 (output size), +0x8 (delay) and +0xC (enable). The first three read back exactly what was written. The enable word keeps only bit 0 and reads 0 in bits 31:1.
- R2: A status word at 0x10_0100 reads 0 after reset. Its bit 0 becomes 1 when a disabled or nonexistent slot is selected, and then stays 1 until reset. Writes to this word have no effect.
- R3: After reset, sel_tready is 1. It goes low in the cycle after a select word is accepted. It stays low until the transaction ends: the last output beat has been transferred, or, for a transaction with no output, the input and delay phases are over.
- R4: Sizes and delay use bits 15:0 of their words, and sizes count 16-bit elements. The engine accepts exactly ceil(input_size/32) beats on the input stream, and in_tready is 1 only while beats are still owed.
- R5: With delay D, the first output tvalid occurs D+1 cycles after the cycle in which the last input beat is accepted. If the input size is 0, the count starts from the cycle in which the select word is accepted.
- R6: A packet has exactly ceil(output_size/32) beats, and out_tlast is 1 only on the final one.
- R7: Each output beat carries the beat index (counting from 0) in out_tdata[15:0] and the model number in out_tdata[31:16]. All other data bits are 0.
- R8: out_tkeep is all ones on every beat except the last. On the last beat, with r = output_size mod 32 (taken as 32 when the remainder is 0), exactly the low 2·r byte-enable bits are 1.
- R9: Selecting a disabled slot makes the engine consume that slot's configured input beats. Selecting a number of 4 or more consumes none. In both cases no output beat is produced and the engine then returns to accepting select words.
- R10: While out_tvalid is 1 and out_tready is 0, out_tvalid, out_tdata, out_tkeep and out_tlast hold their values.
- R11: Configuration writes honour wstrb byte by byte. bresp and rresp are always OKAY (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_awaddr | input | 24 | Write address |
| cfg_awvalid | input | 1 | Write address valid |
| cfg_awready | output | 1 | Write address ready |
| cfg_wdata | input | 32 | Write data |
| cfg_wstrb | input | 4 | Write byte strobes |
| cfg_wvalid | input | 1 | Write data valid |
| cfg_wready | output | 1 | Write data ready |
| cfg_bresp | output | 2 | Write response |
| cfg_bvalid | output | 1 | Write response valid |
| cfg_bready | input | 1 | Write response ready |
| cfg_araddr | input | 24 | Read address |
| cfg_arvalid | input | 1 | Read address valid |
| cfg_arready | output | 1 | Read address ready |
| cfg_rdata | output | 32 | Read data |
| cfg_rresp | output | 2 | Read response |
| cfg_rvalid | output | 1 | Read data valid |
| cfg_rready | input | 1 | Read data ready |
| sel_tdata | input | 8 | Model number |
| sel_tvalid | input | 1 | Select valid |
| sel_tready | output | 1 | Select ready |
| in_tdata | input | 512 | Input payload (discarded) |
| in_tvalid | input | 1 | Input valid |
| in_tready | output | 1 | Input ready |
| out_tdata | output | 512 | Synthetic output payload |
| out_tkeep | output | 64 | Byte valid mask |
| out_tlast | output | 1 | Last beat of packet |
| out_tvalid | output | 1 | Output valid |
| out_tready | input | 1 | Output ready |

## Verification
Directed transactions cover several shapes. Sizes that are exact multiples of the beat width separate correct full-width masks from partial ones. Sizes with remainders expose errors in the byte count and in the rounding of the beat count. A zero input size exercises the alternative reference point for the delay count, and zero and nonzero delays separate off-by-one errors in the wait phase. Randomly drawn sizes and delays are then run with gaps in the input and random output backpressure. This catches counters that advance on valid rather than on a handshake, and payloads that change while stalled. Disabled and nonexistent slots check that input is drained with no output, that the status bit is sticky, and that writes to status are ignored.

// File: rtl/stub_eng_pkg.sv
package stub_eng_pkg;

    localparam int BLOCK_SIZE_DEF = 32;
    localparam int NUM_MODELS_DEF = 4;
    localparam int ADDR_W_DEF     = 24;
    localparam int SEL_W_DEF      = 8;

    localparam logic [31:0] WIN_BASE   = 32'h0010_0000;
    localparam logic [11:0] STATUS_OFF = 12'h100;

    typedef struct packed {
        logic [31:0] in_size;
        logic [31:0] out_size;
        logic [31:0] delay;
        logic        enable;
    } model_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_IN,
        ST_WAIT,
        ST_OUT
    } eng_state_e;

    // number of beats needed for n elements with 2**lg elements per beat
    function automatic logic [16:0] beats_for(input logic [15:0] n, input int lg);
        logic [16:0] sum;
        sum = {1'b0, n} + 17'((1 << lg) - 1);
        return sum >> lg;
    endfunction

endpackage

// File: rtl/stub_cfg_regs.sv
module stub_cfg_regs
    import stub_eng_pkg::*;
#(
    parameter int NUM_MODELS = NUM_MODELS_DEF,
    parameter int ADDR_W     = ADDR_W_DEF
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [ADDR_W-1:0]            awaddr,
    input  logic                         awvalid,
    output logic                         awready,
    input  logic [31:0]                  wdata,
    input  logic [3:0]                   wstrb,
    input  logic                         wvalid,
    output logic                         wready,
    output logic                         bvalid,
    input  logic                         bready,
    input  logic [ADDR_W-1:0]            araddr,
    input  logic                         arvalid,
    output logic                         arready,
    output logic [31:0]                  rdata,
    output logic                         rvalid,
    input  logic                         rready,
    input  logic                         err_set,
    output model_cfg_t [NUM_MODELS-1:0]  cfg
);

    logic [31:0] in_sz_q  [NUM_MODELS];
    logic [31:0] out_sz_q [NUM_MODELS];
    logic [31:0] dly_q    [NUM_MODELS];
    logic        en_q     [NUM_MODELS];
    logic        err_q;

    logic wr_fire, rd_fire, aw_win, ar_win;
    logic [31:0] rd_word;

    assign aw_win  = awaddr[ADDR_W-1:12] == WIN_BASE[ADDR_W-1:12];
    assign ar_win  = araddr[ADDR_W-1:12] == WIN_BASE[ADDR_W-1:12];
    assign awready = awvalid && wvalid && !bvalid;
    assign wready  = awready;
    assign wr_fire = awready;
    assign arready = !rvalid;
    assign rd_fire = arvalid && arready;

    logic unused_addr_lo;
    assign unused_addr_lo = ^{awaddr[1:0], araddr[1:0], wdata[31:8] & 24'h0};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_MODELS; s++) begin
                in_sz_q[s]  <= '0;
                out_sz_q[s] <= '0;
                dly_q[s]    <= '0;
                en_q[s]     <= 1'b0;
            end
        end else if (wr_fire && aw_win && awaddr[11:8] == 4'h0) begin
            for (int s = 0; s < NUM_MODELS; s++) begin
                if (awaddr[7:4] == 4'(s)) begin
                    for (int by = 0; by < 4; by++) begin
                        if (wstrb[by]) begin
                            case (awaddr[3:2])
                                2'd0:    in_sz_q[s][by*8 +: 8]  <= wdata[by*8 +: 8];
                                2'd1:    out_sz_q[s][by*8 +: 8] <= wdata[by*8 +: 8];
                                2'd2:    dly_q[s][by*8 +: 8]    <= wdata[by*8 +: 8];
                                default: if (by == 0) en_q[s]   <= wdata[0];
                            endcase
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else if (err_set) err_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) bvalid <= 1'b0;
        else if (wr_fire) bvalid <= 1'b1;
        else if (bready) bvalid <= 1'b0;
    end

    always_comb begin
        rd_word = '0;
        if (ar_win) begin
            if (araddr[11:0] == STATUS_OFF) begin
                rd_word = {31'b0, err_q};
            end else if (araddr[11:8] == 4'h0) begin
                for (int s = 0; s < NUM_MODELS; s++) begin
                    if (araddr[7:4] == 4'(s)) begin
                        case (araddr[3:2])
                            2'd0:    rd_word = in_sz_q[s];
                            2'd1:    rd_word = out_sz_q[s];
                            2'd2:    rd_word = dly_q[s];
                            default: rd_word = {31'b0, en_q[s]};
                        endcase
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else if (rd_fire) begin
            rvalid <= 1'b1;
            rdata  <= rd_word;
        end else if (rready) begin
            rvalid <= 1'b0;
        end
    end

    generate
        for (genvar g = 0; g < NUM_MODELS; g++) begin : g_cfg
            assign cfg[g].in_size  = in_sz_q[g];
            assign cfg[g].out_size = out_sz_q[g];
            assign cfg[g].delay    = dly_q[g];
            assign cfg[g].enable   = en_q[g];
        end
    endgenerate

endmodule

// File: rtl/stub_txn_seq.sv
module stub_txn_seq
    import stub_eng_pkg::*;
#(
    parameter int BLOCK_SIZE = BLOCK_SIZE_DEF,
    parameter int NUM_MODELS = NUM_MODELS_DEF,
    parameter int SEL_W      = SEL_W_DEF
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  model_cfg_t [NUM_MODELS-1:0]          cfg,
    input  logic [SEL_W-1:0]                     sel_tdata,
    input  logic                                 sel_tvalid,
    output logic                                 sel_tready,
    input  logic                                 in_tvalid,
    output logic                                 in_tready,
    output logic                                 out_tvalid,
    input  logic                                 out_tready,
    output logic                                 out_last,
    output logic [15:0]                          beat_idx,
    output logic [SEL_W-1:0]                     model_num,
    output logic [$clog2(BLOCK_SIZE):0]          rem_elems,
    output logic                                 err_set
);

    localparam int LOG_B = $clog2(BLOCK_SIZE);
    localparam int IDX_W = (NUM_MODELS > 1) ? $clog2(NUM_MODELS) : 1;

    eng_state_e         state_q;
    logic [SEL_W-1:0]   model_q;
    logic               drop_q;
    logic [16:0]        left_q;
    logic [16:0]        nbeats_q;
    logic [16:0]        beat_q;
    logic [LOG_B-1:0]   rem_q;
    logic [15:0]        dly_q;

    model_cfg_t  chosen;
    logic        in_range, sel_ok;
    logic        sel_fire, in_fire, out_fire;
    logic [16:0] sel_in_beats;

    // where the engine goes once the input phase is over
    logic [15:0] pi_dly;
    logic [16:0] pi_nbeats;
    logic        pi_drop;
    eng_state_e  pi_state;
    logic [15:0] pi_cnt;

    assign in_range = sel_tdata < SEL_W'(NUM_MODELS);
    assign chosen   = cfg[sel_tdata[IDX_W-1:0]];
    assign sel_ok   = in_range && chosen.enable;
    assign sel_in_beats = in_range ? beats_for(chosen.in_size[15:0], LOG_B) : 17'd0;

    logic unused_cfg_hi;
    assign unused_cfg_hi = ^{chosen.in_size[31:16], chosen.out_size[31:16], chosen.delay[31:16]};

    assign sel_tready = state_q == ST_IDLE;
    assign in_tready  = state_q == ST_IN;
    assign out_tvalid = state_q == ST_OUT;
    assign sel_fire   = sel_tvalid && sel_tready;
    assign in_fire    = in_tvalid && in_tready;
    assign out_fire   = out_tvalid && out_tready;
    assign out_last   = out_tvalid && (beat_q == nbeats_q - 17'd1);
    assign beat_idx   = beat_q[15:0];
    assign model_num  = model_q;
    assign rem_elems  = (rem_q == '0) ? (LOG_B+1)'(BLOCK_SIZE) : {1'b0, rem_q};
    assign err_set    = sel_fire && !sel_ok;

    always_comb begin
        pi_dly    = (state_q == ST_IDLE) ? chosen.delay[15:0] : dly_q;
        pi_nbeats = (state_q == ST_IDLE) ? beats_for(chosen.out_size[15:0], LOG_B) : nbeats_q;
        pi_drop   = (state_q == ST_IDLE) ? !sel_ok : drop_q;
        pi_cnt    = '0;
        if (pi_drop) begin
            pi_state = ST_IDLE;
        end else if (pi_dly != 16'd0) begin
            pi_state = ST_WAIT;
            pi_cnt   = pi_dly - 16'd1;
        end else if (pi_nbeats == 17'd0) begin
            pi_state = ST_IDLE;
        end else begin
            pi_state = ST_OUT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            model_q  <= '0;
            drop_q   <= 1'b0;
            left_q   <= '0;
            nbeats_q <= '0;
            beat_q   <= '0;
            rem_q    <= '0;
            dly_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (sel_fire) begin
                    model_q  <= sel_tdata;
                    drop_q   <= !sel_ok;
                    left_q   <= sel_in_beats;
                    nbeats_q <= sel_ok ? pi_nbeats : 17'd0;
                    rem_q    <= chosen.out_size[LOG_B-1:0];
                    dly_q    <= chosen.delay[15:0];
                    beat_q   <= '0;
                    if (sel_in_beats != 17'd0) begin
                        state_q <= ST_IN;
                    end else begin
                        // spend at least one cycle busy, even with nothing to do
                        state_q <= (pi_state == ST_IDLE) ? ST_WAIT : pi_state;
                        dly_q   <= pi_cnt;
                    end
                end
                ST_IN: if (in_fire) begin
                    left_q <= left_q - 17'd1;
                    if (left_q == 17'd1) begin
                        state_q <= pi_state;
                        dly_q   <= pi_cnt;
                    end
                end
                ST_WAIT: begin
                    if (dly_q == 16'd0) state_q <= (nbeats_q == 17'd0) ? ST_IDLE : ST_OUT;
                    else dly_q <= dly_q - 16'd1;
                end
                ST_OUT: if (out_fire) begin
                    beat_q <= beat_q + 17'd1;
                    if (out_last) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/stub_beat_gen.sv
module stub_beat_gen
    import stub_eng_pkg::*;
#(
    parameter int BLOCK_SIZE = BLOCK_SIZE_DEF,
    parameter int SEL_W      = SEL_W_DEF
) (
    input  logic [15:0]                 beat_idx,
    input  logic [SEL_W-1:0]            model_num,
    input  logic                        last,
    input  logic [$clog2(BLOCK_SIZE):0] rem_elems,
    output logic [BLOCK_SIZE*16-1:0]    tdata,
    output logic [BLOCK_SIZE*2-1:0]     tkeep
);

    localparam int LOG_B  = $clog2(BLOCK_SIZE);
    localparam int KW     = LOG_B + 2;
    localparam int KEEP_W = BLOCK_SIZE * 2;

    logic [KW-1:0] valid_bytes;
    assign valid_bytes = {rem_elems, 1'b0};

    always_comb begin
        tdata = '0;
        tdata[15:0] = beat_idx;
        tdata[16 +: SEL_W] = model_num;
    end

    generate
        for (genvar b = 0; b < KEEP_W; b++) begin : g_keep
            assign tkeep[b] = !last || (KW'(b) < valid_bytes);
        end
    endgenerate

endmodule

// File: rtl/stub_infer_engine.sv
module stub_infer_engine
    import stub_eng_pkg::*;
#(
    parameter int BLOCK_SIZE = BLOCK_SIZE_DEF,
    parameter int NUM_MODELS = NUM_MODELS_DEF,
    parameter int ADDR_W     = ADDR_W_DEF,
    parameter int SEL_W      = SEL_W_DEF
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [ADDR_W-1:0]          cfg_awaddr,
    input  logic                       cfg_awvalid,
    output logic                       cfg_awready,
    input  logic [31:0]                cfg_wdata,
    input  logic [3:0]                 cfg_wstrb,
    input  logic                       cfg_wvalid,
    output logic                       cfg_wready,
    output logic [1:0]                 cfg_bresp,
    output logic                       cfg_bvalid,
    input  logic                       cfg_bready,
    input  logic [ADDR_W-1:0]          cfg_araddr,
    input  logic                       cfg_arvalid,
    output logic                       cfg_arready,
    output logic [31:0]                cfg_rdata,
    output logic [1:0]                 cfg_rresp,
    output logic                       cfg_rvalid,
    input  logic                       cfg_rready,
    input  logic [SEL_W-1:0]           sel_tdata,
    input  logic                       sel_tvalid,
    output logic                       sel_tready,
    input  logic [BLOCK_SIZE*16-1:0]   in_tdata,
    input  logic                       in_tvalid,
    output logic                       in_tready,
    output logic [BLOCK_SIZE*16-1:0]   out_tdata,
    output logic [BLOCK_SIZE*2-1:0]    out_tkeep,
    output logic                       out_tlast,
    output logic                       out_tvalid,
    input  logic                       out_tready
);

    localparam int LOG_B  = $clog2(BLOCK_SIZE);
    localparam int DATA_W = BLOCK_SIZE * 16;
    localparam int KEEP_W = BLOCK_SIZE * 2;

    model_cfg_t [NUM_MODELS-1:0] cfg;
    logic                        err_set;
    logic [15:0]                 beat_idx;
    logic [SEL_W-1:0]            model_num;
    logic [LOG_B:0]              rem_elems;

    logic unused_in_payload;
    assign unused_in_payload = ^in_tdata;

    assign cfg_bresp = 2'b00;
    assign cfg_rresp = 2'b00;

    stub_cfg_regs #(.NUM_MODELS(NUM_MODELS), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .awaddr  (cfg_awaddr),
        .awvalid (cfg_awvalid),
        .awready (cfg_awready),
        .wdata   (cfg_wdata),
        .wstrb   (cfg_wstrb),
        .wvalid  (cfg_wvalid),
        .wready  (cfg_wready),
        .bvalid  (cfg_bvalid),
        .bready  (cfg_bready),
        .araddr  (cfg_araddr),
        .arvalid (cfg_arvalid),
        .arready (cfg_arready),
        .rdata   (cfg_rdata),
        .rvalid  (cfg_rvalid),
        .rready  (cfg_rready),
        .err_set (err_set),
        .cfg     (cfg)
    );

    stub_txn_seq #(.BLOCK_SIZE(BLOCK_SIZE), .NUM_MODELS(NUM_MODELS), .SEL_W(SEL_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cfg),
        .sel_tdata  (sel_tdata),
        .sel_tvalid (sel_tvalid),
        .sel_tready (sel_tready),
        .in_tvalid  (in_tvalid),
        .in_tready  (in_tready),
        .out_tvalid (out_tvalid),
        .out_tready (out_tready),
        .out_last   (out_tlast),
        .beat_idx   (beat_idx),
        .model_num  (model_num),
        .rem_elems  (rem_elems),
        .err_set    (err_set)
    );

    stub_beat_gen #(.BLOCK_SIZE(BLOCK_SIZE), .SEL_W(SEL_W)) u_beat (
        .beat_idx  (beat_idx),
        .model_num (model_num),
        .last      (out_tlast),
        .rem_elems (rem_elems),
        .tdata     (out_tdata),
        .tkeep     (out_tkeep)
    );

endmodule

// File: rtl/stub_infer_engine_chk.sv
module stub_infer_engine_chk #(
    parameter int DATA_W = 512,
    parameter int KEEP_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              sel_tvalid,
    input logic              sel_tready,
    input logic              in_tready,
    input logic              out_tvalid,
    input logic              out_tready,
    input logic              out_tlast,
    input logic [DATA_W-1:0] out_tdata,
    input logic [KEEP_W-1:0] out_tkeep,
    input logic              cfg_bvalid,
    input logic              cfg_bready,
    input logic              cfg_rvalid,
    input logic              cfg_rready,
    input logic [31:0]       cfg_rdata
);

    // R3
    sel_busy_chk: assert property (@(posedge clk) disable iff (rst)
        sel_tvalid && sel_tready |=> !sel_tready);

    // R4
    phase_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(in_tready && out_tvalid));

    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_tvalid && !out_tready |=> out_tvalid && $stable(out_tdata)
            && $stable(out_tkeep) && $stable(out_tlast));

    // R8
    full_keep_chk: assert property (@(posedge clk) disable iff (rst)
        out_tvalid && !out_tlast |-> &out_tkeep);

    // R7
    beat_step_chk: assert property (@(posedge clk) disable iff (rst)
        out_tvalid && out_tready && !out_tlast |=> out_tvalid
            && (out_tdata[15:0] == $past(out_tdata[15:0]) + 16'd1));

    // R11
    bresp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_bvalid && !cfg_bready |=> cfg_bvalid);

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_rvalid && !cfg_rready |=> cfg_rvalid && $stable(cfg_rdata));

endmodule

bind stub_infer_engine stub_infer_engine_chk #(.DATA_W(DATA_W), .KEEP_W(KEEP_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sel_tvalid (sel_tvalid),
    .sel_tready (sel_tready),
    .in_tready  (in_tready),
    .out_tvalid (out_tvalid),
    .out_tready (out_tready),
    .out_tlast  (out_tlast),
    .out_tdata  (out_tdata),
    .out_tkeep  (out_tkeep),
    .cfg_bvalid (cfg_bvalid),
    .cfg_bready (cfg_bready),
    .cfg_rvalid (cfg_rvalid),
    .cfg_rready (cfg_rready),
    .cfg_rdata  (cfg_rdata)
);

// File: tb/stub_infer_engine_tb.sv
module stub_infer_engine_tb;

    localparam int BLK    = 32;
    localparam int DATA_W = BLK * 16;
    localparam int KEEP_W = BLK * 2;
    localparam logic [23:0] BASE = 24'h10_0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [23:0] awaddr = '0, araddr = '0;
    logic awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic awready, wready, bvalid, arready, rvalid;
    logic [1:0]  bresp, rresp;
    logic [31:0] rdata;
    logic [7:0]  sel_data = '0;
    logic sel_valid = 0, sel_ready;
    logic [DATA_W-1:0] in_data = '0;
    logic in_valid = 0, in_ready;
    logic [DATA_W-1:0] out_data;
    logic [KEEP_W-1:0] out_keep;
    logic out_last, out_valid;
    logic out_ready = 0;

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    stub_infer_engine u_dut (
        .clk(clk), .rst(rst),
        .cfg_awaddr(awaddr), .cfg_awvalid(awvalid), .cfg_awready(awready),
        .cfg_wdata(wdata), .cfg_wstrb(wstrb), .cfg_wvalid(wvalid), .cfg_wready(wready),
        .cfg_bresp(bresp), .cfg_bvalid(bvalid), .cfg_bready(bready),
        .cfg_araddr(araddr), .cfg_arvalid(arvalid), .cfg_arready(arready),
        .cfg_rdata(rdata), .cfg_rresp(rresp), .cfg_rvalid(rvalid), .cfg_rready(rready),
        .sel_tdata(sel_data), .sel_tvalid(sel_valid), .sel_tready(sel_ready),
        .in_tdata(in_data), .in_tvalid(in_valid), .in_tready(in_ready),
        .out_tdata(out_data), .out_tkeep(out_keep), .out_tlast(out_last),
        .out_tvalid(out_valid), .out_tready(out_ready)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int ceil_beats(input int n);
        return (n + BLK - 1) / BLK;
    endfunction

    function automatic logic [KEEP_W-1:0] exp_keep(input bit last, input int osz);
        int r;
        logic [KEEP_W-1:0] k;
        r = osz % BLK;
        if (r == 0) r = BLK;
        k = '1;
        if (last) for (int b = 0; b < KEEP_W; b++) k[b] = (b < 2 * r);
        return k;
    endfunction

    function automatic logic [DATA_W-1:0] exp_data(input int beat, input int m);
        logic [DATA_W-1:0] d;
        d = '0;
        d[15:0]  = 16'(beat);
        d[31:16] = 16'(m);
        return d;
    endfunction

    task automatic axi_wr(input logic [23:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        awaddr = a; awvalid = 1; wdata = d; wstrb = s; wvalid = 1;
        #1;
        while (!awready) begin @(negedge clk); #1; end
        @(negedge clk);
        awvalid = 0; wvalid = 0; bready = 1;
        #1;
        while (!bvalid) begin @(negedge clk); #1; end
        chk(bresp == 2'b00, "R11", "bresp", DATA_W'(bresp), '0);
        @(negedge clk);
        bready = 0;
    endtask

    task automatic axi_rd(input logic [23:0] a, output logic [31:0] d);
        @(negedge clk);
        araddr = a; arvalid = 1;
        #1;
        while (!arready) begin @(negedge clk); #1; end
        @(negedge clk);
        arvalid = 0; rready = 1;
        #1;
        while (!rvalid) begin @(negedge clk); #1; end
        d = rdata;
        chk(rresp == 2'b00, "R11", "rresp", DATA_W'(rresp), '0);
        @(negedge clk);
        rready = 0;
    endtask

    task automatic program_slot(input int m, input int isz, input int osz, input int dly, input bit en);
        axi_wr(BASE + 24'(16 * m) + 24'h0, 32'(isz), 4'hF);
        axi_wr(BASE + 24'(16 * m) + 24'h4, 32'(osz), 4'hF);
        axi_wr(BASE + 24'(16 * m) + 24'h8, 32'(dly), 4'hF);
        axi_wr(BASE + 24'(16 * m) + 24'hC, {31'b0, en}, 4'hF);
    endtask

    // one transaction; good = slot enabled and in range
    task automatic run_txn(input int m, input int nin, input int osz, input int dly, input bit good);
        int refc, beat, nb, guard;
        bit first, stalled, seen_out;
        logic [DATA_W-1:0] sd;
        logic [KEEP_W-1:0] sk;
        logic sl;
        nb = ceil_beats(osz);
        @(negedge clk);
        sel_data = 8'(m); sel_valid = 1;
        #1;
        while (!sel_ready) begin @(negedge clk); #1; end
        refc = cyc;
        @(negedge clk);
        sel_valid = 0;
        #1;
        chk(!sel_ready, "R3", "sel_tready after accept", DATA_W'(sel_ready), '0);
        for (int k = 0; k < nin; k++) begin
            if ($urandom % 5 == 0) begin in_valid = 0; @(negedge clk); end
            in_valid = 1; in_data = {16{$urandom}};
            #1;
            while (!in_ready) begin @(negedge clk); #1; end
            refc = cyc;
            @(negedge clk);
        end
        in_valid = 0;
        #1;
        chk(!in_ready, "R4", "in_tready after owed beats", DATA_W'(in_ready), '0);
        if (!good) begin
            seen_out = 0;
            for (int t = 0; t < 20; t++) begin
                @(negedge clk); #1;
                if (out_valid) seen_out = 1;
            end
            chk(!seen_out, "R9", "output for bad model", DATA_W'(seen_out), '0);
            chk(sel_ready && !in_ready, "R9", "idle after bad model",
                DATA_W'({sel_ready, in_ready}), DATA_W'(2'b10));
            return;
        end
        beat = 0; first = 1; stalled = 0; guard = 0;
        sd = '0; sk = '0; sl = 0;
        while (beat < nb && guard < 20000) begin
            out_ready = ($urandom % 3) != 0;
            #1;
            if (stalled)
                chk(out_valid && out_data == sd && out_keep == sk && out_last == sl,
                    "R10", "held beat", out_data, sd);
            if (out_valid && first) begin
                chk(cyc == refc + 1 + dly, "R5", "first tvalid cycle",
                    DATA_W'(cyc), DATA_W'(refc + 1 + dly));
                first = 0;
            end
            stalled = out_valid && !out_ready;
            sd = out_data; sk = out_keep; sl = out_last;
            if (out_valid && out_ready) begin
                chk(out_data == exp_data(beat, m), "R7", "payload", out_data, exp_data(beat, m));
                chk(out_keep == exp_keep(beat == nb - 1, osz), "R8", "tkeep",
                    DATA_W'(out_keep), DATA_W'(exp_keep(beat == nb - 1, osz)));
                chk(out_last == (beat == nb - 1), "R6", "tlast",
                    DATA_W'(out_last), DATA_W'(beat == nb - 1));
                beat++;
            end
            guard++;
            @(negedge clk);
        end
        out_ready = 0;
        chk(beat == nb, "R6", "beat count", DATA_W'(beat), DATA_W'(nb));
        #1;
        chk(sel_ready && !out_valid, "R3", "ready after packet",
            DATA_W'({sel_ready, out_valid}), DATA_W'(2'b10));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        int isz, osz, dly;
        void'($urandom(32'h1234_5eed));
        repeat (5) @(negedge clk);
        rst = 0;
        #1;
        chk(sel_ready && !in_ready && !out_valid, "R3", "reset state",
            DATA_W'({sel_ready, in_ready, out_valid}), DATA_W'(3'b100));
        axi_rd(BASE + 24'h100, rv);
        chk(rv == 0, "R2", "status after reset", DATA_W'(rv), '0);

        program_slot(0, 64, 64, 3, 1);
        program_slot(1, 40, 70, 0, 1);
        program_slot(2, 5, 1, 7, 0);
        program_slot(3, 0, 33, 2, 1);
        axi_wr(BASE + 24'h1C, 32'hFFFF_FFFF, 4'hF);
        axi_rd(BASE + 24'h10, rv); chk(rv == 40, "R1", "slot1 in size", DATA_W'(rv), 40);
        axi_rd(BASE + 24'h14, rv); chk(rv == 70, "R1", "slot1 out size", DATA_W'(rv), 70);
        axi_rd(BASE + 24'h18, rv); chk(rv == 0, "R1", "slot1 delay", DATA_W'(rv), 0);
        axi_rd(BASE + 24'h1C, rv); chk(rv == 1, "R1", "slot1 enable bit only", DATA_W'(rv), 1);
        axi_rd(BASE + 24'h38, rv); chk(rv == 2, "R1", "slot3 delay", DATA_W'(rv), 2);
        axi_rd(BASE + 24'h2C, rv); chk(rv == 0, "R1", "slot2 enable", DATA_W'(rv), 0);

        axi_wr(BASE + 24'h28, 32'hFFFF_FFFF, 4'hF);
        axi_wr(BASE + 24'h28, 32'hAAAA_AA12, 4'h1);
        axi_rd(BASE + 24'h28, rv);
        chk(rv == 32'hFFFF_FF12, "R11", "byte strobe write", DATA_W'(rv), DATA_W'(32'hFFFF_FF12));
        axi_wr(BASE + 24'h28, 32'd7, 4'hF);

        run_txn(0, ceil_beats(64), 64, 3, 1);
        run_txn(1, ceil_beats(40), 70, 0, 1);
        run_txn(3, 0, 33, 2, 1);

        for (int i = 0; i < 10; i++) begin
            isz = $urandom % 101;
            osz = 1 + $urandom % 100;
            dly = $urandom % 11;
            program_slot(0, isz, osz, dly, 1);
            run_txn(0, ceil_beats(isz), osz, dly, 1);
        end

        run_txn(2, ceil_beats(5), 0, 0, 0);
        axi_rd(BASE + 24'h100, rv);
        chk(rv == 1, "R2", "status after disabled select", DATA_W'(rv), 1);
        run_txn(9, 0, 0, 0, 0);
        axi_wr(BASE + 24'h100, 32'h0, 4'hF);
        axi_rd(BASE + 24'h100, rv);
        chk(rv == 1, "R2", "status sticky after write", DATA_W'(rv), 1);
        run_txn(1, ceil_beats(40), 70, 0, 1);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule